// File: doc/BRIEF.md
# Two-Wire Clock/Calendar Slave with Byte-Wide Storage

This block is the serial slave front end of a clock/calendar device that also holds nonvolatile bytes. It watches a two-wire bus (a clock line and an open-drain data line), picks out start and stop conditions, and answers only when the first byte after a start carries its own identifier and select code. A write transaction carries a 16-bit word address, sent high byte first, and at most one data byte. A read returns bytes from the current address and steps the address forward for as long as the master acknowledges.

Three kinds of target share the address space: a storage array, a small bank of clock/control registers, and one status byte. The status byte holds a write-enable latch, an arm bit for clock writes and a two-bit block-protect field. A data byte is acknowledged or refused according to those bits and to the kind of target. A write is carried out only when the stop arrives. An accepted storage write then starts a modelled programming cycle, and the slave ignores the bus until that cycle is over.

The bus lines are brought into the clock domain of the block through a synchronizer and are sampled there. SDA is driven only as a low-pull enable.

Top module: `twowire_rtc_slave`

## Requirements
- R1: No byte is acknowledged and SDA is never pulled until a start (SDA falling while SCL is high) has been seen. A stop (SDA rising while SCL is high) returns the slave to idle. The slave changes its SDA drive only while SCL is low.
- R2: The first byte after a start is taken MSB first. Bits 7:4 must equal 1101, bits 3:1 must equal DEV_SEL, and bit 0 selects read (1) or write (0). The byte is acknowledged by pulling SDA low in the 9th clock only on a match.
- R3: The two bytes after a write address byte are always acknowledged and form the pointer, high byte first. Addresses 0..MEM_DEPTH-1 select the array, CLK_BASE..CLK_BASE+CLK_REGS-1 select the clock registers and STAT_ADDR selects the status byte. Any other address reads as FFh, and its data bytes are not acknowledged.
- R4: While the write-enable latch is 0, data bytes aimed at the array or at the clock registers are not acknowledged and change nothing.
- R5: A write accepts one data byte. A second data byte is not acknowledged, and the first byte is still committed at the stop.
- R6: Status byte layout: bit 1 is the write-enable latch, bit 2 is the clock-write arm and bits 4:3 are the protect field; the other bits read 0. Data sent to the status byte is always acknowledged. Writing 02h sets the latch and clears the arm. Writing 06h sets the arm only while the latch is 1. Writing 00h clears both. Any other value, written while armed, loads the protect field from data bits 4:3 and clears the arm.
- R7: A clock-register data byte is acknowledged only when both the latch and the arm are 1. Committing that write clears the arm, and it starts no programming cycle.
- R8: Protect field 1 guards the top quarter of the array, 2 guards the top half and 3 guards all of it. A write to a guarded byte is acknowledged but discarded, and it starts no programming cycle.
- R9: A write is performed only at the stop that closes its transaction. A repeated start before that stop discards it.
- R10: An accepted array write raises wr_busy for TWC_CYCLES clocks, starting right after the stop. While wr_busy is high the slave acknowledges nothing and keeps SDA released.
- R11: A read sends the addressed byte MSB first. On each master acknowledge the pointer steps by one, wrapping from the last array byte to address 0, and the next byte follows.
- R12: When the master does not acknowledge a read byte, the slave releases SDA and ignores further clocks until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level as seen on the wire |
| sda_pull | output | 1 | Pulls the data line low when 1; the line is released when 0 |
| wr_busy | output | 1 | High while a modelled programming cycle runs |

## Verification
The assertions assume a master that moves SDA only while SCL is low, except to form start and stop conditions. They also assume that every SCL level is held for several block clocks, so the synchronized edges of SCL and SDA stay well apart. The bench keeps to this by driving the bus from tasks that wait four clocks between any two line changes, and by never toggling SDA and SCL in the same step except at a falling SCL edge. The one exception is a deliberate run of clocks with no start in front of it; it keeps the same spacing and is used to show that the slave does not respond.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WA1,
    PH_WA2,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    RG_MEM,
    RG_CLK,
    RG_STAT,
    RG_NONE
  } region_t;

endpackage

// File: rtl/rtcs_bus_sense.sv
module rtcs_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_in;
          sda_sh <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
          sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_sh[SYNC_STAGES-1];
  assign sda_lvl = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/rtcs_nvarray.sv
module rtcs_nvarray #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/rtcs_ctlregs.sv
module rtcs_ctlregs #(
  parameter int CLK_REGS = 8,
  localparam int IW = $clog2(CLK_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_we,
  input  logic [IW-1:0] clk_widx,
  input  logic [7:0]    wdata,
  input  logic          stat_we,
  input  logic [IW-1:0] clk_ridx,
  output logic [7:0]    clk_rdata,
  output logic          wel,
  output logic          rwel,
  output logic [1:0]    bp
);

  logic [7:0] regs [CLK_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CLK_REGS; i++) regs[i] <= 8'h00;
      clk_rdata <= 8'h00;
    end else begin
      if (clk_we) regs[clk_widx] <= wdata;
      clk_rdata <= regs[clk_ridx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
      bp   <= 2'b00;
    end else if (stat_we) begin
      case (wdata)
        8'h02: begin
          wel  <= 1'b1;
          rwel <= 1'b0;
        end
        8'h06: if (wel) rwel <= 1'b1;
        8'h00: begin
          wel  <= 1'b0;
          rwel <= 1'b0;
        end
        default: if (rwel) begin
          bp   <= wdata[4:3];
          rwel <= 1'b0;
        end
      endcase
    end else if (clk_we) begin
      rwel <= 1'b0;
    end
  end

endmodule

// File: rtl/rtcs_wtimer.sv
module rtcs_wtimer #(
  parameter int CYCLES = 5000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (go) begin
      cnt  <= CW'(CYCLES - 1);
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/twowire_rtc_slave.sv
module twowire_rtc_slave
  import rtcs_pkg::*;
#(
  parameter int          MEM_DEPTH   = 256,
  parameter int          CLK_REGS    = 8,
  parameter logic [15:0] CLK_BASE    = 16'h0100,
  parameter logic [15:0] STAT_ADDR   = 16'h013F,
  parameter logic [3:0]  DEV_ID      = 4'b1101,
  parameter logic [2:0]  DEV_SEL     = 3'b000,
  parameter int          TWC_CYCLES  = 5000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull,
  output logic wr_busy
);

  localparam int          MAW      = $clog2(MEM_DEPTH);
  localparam int          CIW      = $clog2(CLK_REGS);
  localparam logic [15:0] MEM_LAST = 16'(MEM_DEPTH - 1);
  localparam logic [15:0] Q3_BASE  = 16'(MEM_DEPTH - MEM_DEPTH / 4);
  localparam logic [15:0] H_BASE   = 16'(MEM_DEPTH / 2);
  localparam logic [15:0] CLK_END  = CLK_BASE + 16'(CLK_REGS);
  localparam logic [6:0]  DEV_ADDR = {DEV_ID, DEV_SEL};

  // bus edge detection
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  rtcs_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  // protocol state
  phase_t      phase, next_ph;
  logic [3:0]  bitcnt;
  logic        in_ack, mack, got_data;
  logic [7:0]  shreg, txreg, hi_byte;
  logic [15:0] ptr;

  // write held until stop
  logic        pend_v, pend_prot;
  logic [15:0] pend_addr;
  logic [7:0]  pend_data;
  region_t     pend_rg;

  // storage side
  logic        mem_we, clk_we, stat_we, commit;
  logic [7:0]  mem_rdata, clk_rdata;
  logic        wel, rwel;
  logic [1:0]  bp;

  function automatic region_t decode(input logic [15:0] a);
    if (a <= MEM_LAST)                    return RG_MEM;
    else if (a >= CLK_BASE && a < CLK_END) return RG_CLK;
    else if (a == STAT_ADDR)               return RG_STAT;
    else                                   return RG_NONE;
  endfunction

  function automatic logic guarded(input logic [1:0] f, input logic [15:0] a);
    case (f)
      2'd1:    return a >= Q3_BASE;
      2'd2:    return a >= H_BASE;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  region_t     ptr_rg;
  logic [15:0] ptr_next;
  logic [7:0]  rd_byte, stat_byte;
  logic        wdat_ack, ptr_prot;

  always_comb begin
    ptr_rg    = decode(ptr);
    ptr_prot  = (ptr_rg == RG_MEM) && guarded(bp, ptr);
    ptr_next  = (ptr_rg == RG_MEM && ptr == MEM_LAST) ? 16'h0000 : ptr + 16'd1;
    stat_byte = {3'b000, bp, rwel, wel, 1'b0};
    case (ptr_rg)
      RG_MEM:  rd_byte = mem_rdata;
      RG_CLK:  rd_byte = clk_rdata;
      RG_STAT: rd_byte = stat_byte;
      default: rd_byte = 8'hFF;
    endcase
    case (ptr_rg)
      RG_MEM:  wdat_ack = wel;
      RG_CLK:  wdat_ack = wel & rwel;
      RG_STAT: wdat_ack = 1'b1;
      default: wdat_ack = 1'b0;
    endcase
    wdat_ack = wdat_ack & ~got_data;
  end

  always_comb begin
    commit  = stop_evt && pend_v && !wr_busy;
    mem_we  = commit && pend_rg == RG_MEM && !pend_prot;
    clk_we  = commit && pend_rg == RG_CLK;
    stat_we = commit && pend_rg == RG_STAT;
  end

  rtcs_nvarray #(.DEPTH(MEM_DEPTH)) u_array (
    .clk(clk), .we(mem_we), .waddr(pend_addr[MAW-1:0]), .wdata(pend_data),
    .raddr(ptr[MAW-1:0]), .rdata(mem_rdata)
  );

  rtcs_ctlregs #(.CLK_REGS(CLK_REGS)) u_regs (
    .clk(clk), .rst(rst), .clk_we(clk_we),
    .clk_widx(CIW'(pend_addr - CLK_BASE)), .wdata(pend_data),
    .stat_we(stat_we), .clk_ridx(CIW'(ptr - CLK_BASE)),
    .clk_rdata(clk_rdata), .wel(wel), .rwel(rwel), .bp(bp)
  );

  rtcs_wtimer #(.CYCLES(TWC_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .go(mem_we), .busy(wr_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      next_ph   <= PH_IDLE;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      mack      <= 1'b0;
      got_data  <= 1'b0;
      shreg     <= '0;
      txreg     <= '0;
      hi_byte   <= '0;
      ptr       <= '0;
      pend_v    <= 1'b0;
      pend_prot <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_rg   <= RG_NONE;
      sda_pull  <= 1'b0;
    end else if (wr_busy) begin
      phase    <= PH_IDLE;
      in_ack   <= 1'b0;
      pend_v   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      phase    <= PH_DEV;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      got_data <= 1'b0;
      pend_v   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      phase    <= PH_IDLE;
      in_ack   <= 1'b0;
      pend_v   <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      case (phase)
        PH_DEV, PH_WA1, PH_WA2, PH_WDAT: begin
          if (scl_rise && !in_ack) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end
          if (scl_fall) begin
            if (in_ack) begin
              in_ack <= 1'b0;
              bitcnt <= '0;
              phase  <= next_ph;
              if (next_ph == PH_RDAT) begin
                txreg    <= rd_byte;
                sda_pull <= ~rd_byte[7];
              end else begin
                sda_pull <= 1'b0;
              end
            end else if (bitcnt == 4'd8) begin
              in_ack <= 1'b1;
              case (phase)
                PH_DEV: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    sda_pull <= 1'b1;
                    next_ph  <= shreg[0] ? PH_RDAT : PH_WA1;
                  end else begin
                    next_ph <= PH_SKIP;
                  end
                end
                PH_WA1: begin
                  hi_byte  <= shreg;
                  sda_pull <= 1'b1;
                  next_ph  <= PH_WA2;
                end
                PH_WA2: begin
                  ptr      <= {hi_byte, shreg};
                  sda_pull <= 1'b1;
                  next_ph  <= PH_WDAT;
                end
                default: begin
                  got_data <= 1'b1;
                  if (wdat_ack) begin
                    sda_pull  <= 1'b1;
                    pend_v    <= 1'b1;
                    pend_addr <= ptr;
                    pend_data <= shreg;
                    pend_rg   <= ptr_rg;
                    pend_prot <= ptr_prot;
                    next_ph   <= PH_WDAT;
                  end else begin
                    next_ph <= PH_SKIP;
                  end
                end
              endcase
            end
          end
        end
        PH_RDAT: begin
          if (!in_ack) begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
                in_ack   <= 1'b1;
              end else begin
                txreg    <= {txreg[6:0], 1'b0};
                sda_pull <= ~txreg[6];
              end
            end
          end else begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
              if (!sda_lvl) ptr <= ptr_next;
            end
            if (scl_fall) begin
              in_ack <= 1'b0;
              if (mack) begin
                bitcnt   <= '0;
                txreg    <= rd_byte;
                sda_pull <= ~rd_byte[7];
              end else begin
                phase    <= PH_SKIP;
                sda_pull <= 1'b0;
              end
            end
          end
        end
        default: sda_pull <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/rtcs_chk.sv
module rtcs_chk (
  input logic clk,
  input logic rst,
  input logic sda_pull,
  input logic wr_busy,
  input logic scl_lvl,
  input logic stop_evt,
  input logic mem_we,
  input logic clk_we,
  input logic wel,
  input logic rwel
);

  // R1
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_pull != $past(sda_pull)) |-> !scl_lvl);

  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    wr_busy |-> !sda_pull);

  // R10
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(stop_evt));

  // R4
  mem_we_latch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wel);

  // R7
  clk_relock_chk: assert property (@(posedge clk) disable iff (rst)
    clk_we |=> !rwel);

endmodule

bind twowire_rtc_slave rtcs_chk u_chk (
  .clk(clk), .rst(rst), .sda_pull(sda_pull), .wr_busy(wr_busy),
  .scl_lvl(scl_lvl), .stop_evt(stop_evt), .mem_we(mem_we),
  .clk_we(clk_we), .wel(wel), .rwel(rwel)
);

// File: tb/tb_twowire_rtc_slave.sv
module tb_twowire_rtc_slave;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 4;
  localparam int DEPTH      = 16;
  localparam int TWC        = 200;
  localparam logic [7:0]  DEV_W = 8'hD0;
  localparam logic [7:0]  DEV_R = 8'hD1;
  localparam logic [15:0] STATA = 16'h013F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, wr_busy;
  wire  sda_line = sda_m & ~sda_pull;

  int nvec = 0;
  int nerr = 0;
  int run = 0;
  int last_run = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] rbuf [32];

  always #(CLK_PERIOD / 2) clk = ~clk;

  twowire_rtc_slave #(.MEM_DEPTH(DEPTH), .TWC_CYCLES(TWC)) dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .wr_busy(wr_busy)
  );

  always @(posedge clk) begin
    if (wr_busy) run <= run + 1;
    else if (run != 0) begin
      last_run <= run;
      run <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b0; hw(H);
    scl_m = 1'b0; hw(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b1; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(H);
      scl_m = 1'b1; hw(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H / 2);
    ack = ~sda_line; hw(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw(H);
      scl_m = 1'b1; hw(H / 2);
      b = {b[6:0], sda_line}; hw(H / 2);
      scl_m = 1'b0;
    end
    sda_m = ~mack; hw(H);
    scl_m = 1'b1; hw(H);
    scl_m = 1'b0;
  endtask

  // acks = {dev, hi, lo, d0, d1}; nd data bytes (0..2)
  task automatic wr_xfer(input logic [15:0] a, input int nd, input logic [7:0] d0,
                         input logic [7:0] d1, output logic [4:0] acks);
    acks = '0;
    bus_start();
    send_byte(DEV_W, acks[4]);
    send_byte(a[15:8], acks[3]);
    send_byte(a[7:0], acks[2]);
    if (nd > 0) send_byte(d0, acks[1]);
    if (nd > 1) send_byte(d1, acks[0]);
    bus_stop();
  endtask

  task automatic settle();
    hw(8);
    while (wr_busy) hw(1);
    hw(4);
  endtask

  task automatic rd_seq(input logic [15:0] a, input int n);
    logic k;
    bus_start();
    send_byte(DEV_W, k);
    send_byte(a[15:8], k);
    send_byte(a[7:0], k);
    bus_start();
    send_byte(DEV_R, k);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  function automatic logic guard(input int f, input int a);
    case (f)
      1: return a >= 12;
      2: return a >= 8;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [4:0] acks;
    logic k;
    logic [7:0] b;
    hw(5);
    rst = 1'b0;
    hw(3);
    // R1 / R10 reset state
    chk("R1 pull after reset", sda_pull, 0);
    chk("R10 busy after reset", wr_busy, 0);

    // R1: a valid address byte clocked without a start
    send_byte(DEV_W, k);
    chk("R1 no ack without start", k, 0);
    bus_stop();
    hw(4);

    // R2: sweep every 7-bit address
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, k);
      chk($sformatf("R2 addr %0h", a), k, a == 7'h68);
      bus_stop();
      hw(2);
    end

    // R6: set the latch, arm, then clear arm via protect-field write
    wr_xfer(STATA, 1, 8'h02, 8'h00, acks);
    chk("R6 status 02 acks", acks, 5'b11110);
    rd_seq(STATA, 1);
    chk("R6 status after 02", rbuf[0], 8'h02);
    wr_xfer(STATA, 1, 8'h06, 8'h00, acks);
    rd_seq(STATA, 1);
    chk("R6 status after 06", rbuf[0], 8'h06);
    wr_xfer(STATA, 1, 8'h80, 8'h00, acks);
    rd_seq(STATA, 1);
    chk("R6 status after protect load", rbuf[0], 8'h02);

    // fill the array, R10 busy per write
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = 8'(a * 7 + 3);
      wr_xfer(16'(a), 1, model[a], 8'h00, acks);
      chk("R3 write acks", acks, 5'b11110);
      chk("R10 busy after write", wr_busy, 1);
      settle();
      chk("R10 busy length", last_run, TWC);
    end

    // R11: sequential read across the wrap
    rd_seq(16'h0000, DEPTH + 2);
    for (int i = 0; i < DEPTH + 2; i++)
      chk($sformatf("R11 seq byte %0d", i), rbuf[i], model[i % DEPTH]);
    rd_seq(16'(DEPTH - 1), 2);
    chk("R11 wrap last", rbuf[0], model[DEPTH - 1]);
    chk("R11 wrap first", rbuf[1], model[0]);

    // R8: sweep protect field over all addresses
    for (int f = 1; f < 4; f++) begin
      wr_xfer(STATA, 1, 8'h06, 8'h00, acks);
      wr_xfer(STATA, 1, 8'(8'h80 | (f << 3)), 8'h00, acks);
      rd_seq(STATA, 1);
      chk("R8 status field", rbuf[0], (f << 3) | 2);
      for (int a = 0; a < DEPTH; a++) begin
        b = 8'(a ^ (f * 16 + 5));
        wr_xfer(16'(a), 1, b, 8'h00, acks);
        chk("R8 data ack", acks[1], 1);
        chk("R8 busy only if open", wr_busy, !guard(f, a));
        if (!guard(f, a)) model[a] = b;
        settle();
      end
      rd_seq(16'h0000, DEPTH);
      for (int a = 0; a < DEPTH; a++)
        chk($sformatf("R8 f%0d a%0d", f, a), rbuf[a], model[a]);
    end
    wr_xfer(STATA, 1, 8'h06, 8'h00, acks);
    wr_xfer(STATA, 1, 8'h80, 8'h00, acks);

    // R10: deaf during the programming cycle
    model[2] = 8'h99;
    wr_xfer(16'h0002, 1, 8'h99, 8'h00, acks);
    bus_start();
    send_byte(DEV_W, k);
    chk("R10 no ack while busy", k, 0);
    bus_stop();
    settle();
    rd_seq(16'h0002, 1);
    chk("R10 write kept", rbuf[0], 8'h99);

    // R9: repeated start discards the held write
    bus_start();
    send_byte(DEV_W, k);
    send_byte(8'h00, k);
    send_byte(8'h05, k);
    send_byte(8'h5A, k);
    bus_start();
    send_byte(DEV_R, k);
    recv_byte(1'b0, b);
    bus_stop();
    chk("R9 old value", b, model[5]);
    hw(4);
    chk("R9 no busy", wr_busy, 0);

    // R5: two data bytes to the array
    wr_xfer(16'h0006, 2, 8'h11, 8'h22, acks);
    chk("R5 array second byte nack", acks, 5'b11110);
    settle();
    model[6] = 8'h11;
    rd_seq(16'h0006, 2);
    chk("R5 first committed", rbuf[0], 8'h11);
    chk("R5 next untouched", rbuf[1], model[7]);

    // R7: clock registers
    wr_xfer(16'h0103, 1, 8'h3C, 8'h00, acks);
    chk("R7 nack unarmed", acks[1], 0);
    wr_xfer(STATA, 1, 8'h06, 8'h00, acks);
    wr_xfer(16'h0103, 1, 8'h3C, 8'h00, acks);
    chk("R7 ack armed", acks[1], 1);
    hw(2);
    chk("R7 no busy", wr_busy, 0);
    rd_seq(STATA, 1);
    chk("R7 arm cleared", rbuf[0], 8'h02);
    wr_xfer(STATA, 1, 8'h06, 8'h00, acks);
    wr_xfer(16'h0104, 2, 8'h4D, 8'h77, acks);
    chk("R5 register second byte nack", acks, 5'b11110);
    rd_seq(16'h0103, 3);
    chk("R7 reg3", rbuf[0], 8'h3C);
    chk("R5 reg4", rbuf[1], 8'h4D);
    chk("R5 reg5", rbuf[2], 8'h00);

    // R3: unmapped address
    wr_xfer(16'h0200, 1, 8'h12, 8'h00, acks);
    chk("R3 unmapped acks", acks, 5'b11100);
    rd_seq(16'h0200, 1);
    chk("R3 unmapped read", rbuf[0], 8'hFF);

    // R12: master nack then more clocks
    bus_start();
    send_byte(DEV_W, k);
    send_byte(8'h00, k);
    send_byte(8'h00, k);
    bus_start();
    send_byte(DEV_R, k);
    recv_byte(1'b0, b);
    chk("R12 byte before nack", b, model[0]);
    recv_byte(1'b0, b);
    chk("R12 released after nack", b, 8'hFF);
    bus_stop();

    // R4: latch cleared
    wr_xfer(STATA, 1, 8'h00, 8'h00, acks);
    chk("R6 status 00 ack", acks[1], 1);
    wr_xfer(16'h0003, 1, 8'hEE, 8'h00, acks);
    chk("R4 array nack", acks[1], 0);
    hw(2);
    chk("R4 no busy", wr_busy, 0);
    rd_seq(16'h0003, 1);
    chk("R4 array unchanged", rbuf[0], model[3]);
    wr_xfer(STATA, 1, 8'h06, 8'h00, acks);
    rd_seq(STATA, 1);
    chk("R6 arm needs latch", rbuf[0], 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule